// File: doc/BRIEF.md
# Shift register with carry flag and fill modes

This block is a register of WIDTH bits (four by default) that can be cleared, loaded in parallel, or moved one place left or right per clock. A single flip-flop beside it holds a carry flag, which captures the bit pushed out by the most recent shift. The register contents are always visible on a parallel output. The lowest bit of the register is also presented as a serial output.

A 3-bit operation code picks the action for the next clock edge. On the two shift codes, a 2-bit mode picks the bit that enters at the vacated end:

- logical mode enters a zero;
- arithmetic mode repeats the sign bit on a right shift;
- rotate mode feeds the outgoing bit back in;
- serial mode takes the serial input.

A serial load is therefore a series of right shifts in serial mode. Each register bit is built as its own selector feeding one D flip-flop, so that only neighbouring bits are wired together.

Top module: `shc_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `par_o` becomes all zeros and `carry_o` becomes 0 on that edge, whatever the operation code.
- R2: Operation code 000 leaves `par_o` and `carry_o` unchanged. The unused codes 101, 110 and 111 do the same.
- R3: Operation code 001 copies `par_i` into the register on the next edge and leaves `carry_o` unchanged.
- R4: Operation code 010 (shift left) moves each bit i into bit i+1 and places the old top bit (bit WIDTH-1) into `carry_o`.
- R5: Operation code 011 (shift right) moves each bit i+1 into bit i and places the old bit 0 into `carry_o`.
- R6: With mode 00 (logical), a left shift enters 0 at bit 0 and a right shift enters 0 at bit WIDTH-1.
- R7: With mode 01 (arithmetic), a right shift keeps the old top bit in bit WIDTH-1, and a left shift enters 0 at bit 0.
- R8: With mode 10 (rotate), the bit leaving one end enters at the other end, and the same bit is written to `carry_o`.
- R9: With mode 11 (serial), the entering bit is `ser_i`. It enters at bit WIDTH-1 on a right shift and at bit 0 on a left shift.
- R10: Operation code 100 clears the register and `carry_o` to 0 on the next edge.
- R11: `ser_o` always equals the current bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code for the next edge |
| mode_i | input | 2 | Fill mode used by the shift codes |
| par_i | input | WIDTH | Parallel load data |
| ser_i | input | 1 | Serial fill bit |
| par_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Bit 0 of the register |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the block with WIDTH set to 5. An odd width puts the top bit and the bottom bit at distinct positions from the centre bit. It also means that a rotate needs five steps to return to its start, so three rotates in one direction leave a pattern that cannot be mistaken for a shift in the opposite direction. With this width a serial load of five bits fills the register completely, and repeated arithmetic right shifts show the sign bit spreading across several positions.

// File: rtl/shc_pkg.sv
package shc_pkg;

    localparam logic [2:0] OP_HOLD  = 3'b000;
    localparam logic [2:0] OP_LOAD  = 3'b001;
    localparam logic [2:0] OP_SHL   = 3'b010;
    localparam logic [2:0] OP_SHR   = 3'b011;
    localparam logic [2:0] OP_CLEAR = 3'b100;

    typedef enum logic [1:0] {
        MD_LOGIC = 2'b00,
        MD_ARITH = 2'b01,
        MD_ROT   = 2'b10,
        MD_SER   = 2'b11
    } mode_e;

    // one-hot action strobes; all zero means hold
    typedef struct packed {
        logic clr;
        logic ld;
        logic shl;
        logic shr;
    } ctl_t;

    // bits entering the register at each end
    typedef struct packed {
        logic lo;
        logic hi;
    } fill_t;

    function automatic ctl_t decode_op(input logic [2:0] op);
        ctl_t c;
        c = '0;
        case (op)
            OP_LOAD:  c.ld  = 1'b1;
            OP_SHL:   c.shl = 1'b1;
            OP_SHR:   c.shr = 1'b1;
            OP_CLEAR: c.clr = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

    // bit entering at bit 0 on a left shift
    function automatic logic left_fill(input mode_e m, input logic msb, input logic sin);
        case (m)
            MD_ROT:  return msb;
            MD_SER:  return sin;
            default: return 1'b0;
        endcase
    endfunction

    // bit entering at the top on a right shift
    function automatic logic right_fill(input mode_e m, input logic msb,
                                        input logic lsb, input logic sin);
        case (m)
            MD_ARITH: return msb;
            MD_ROT:   return lsb;
            MD_SER:   return sin;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/shc_decode.sv
module shc_decode
    import shc_pkg::*;
(
    input  logic [2:0] op_i,
    output ctl_t       ctl_o
);
    always_comb ctl_o = decode_op(op_i);
endmodule

// File: rtl/shc_edge.sv
module shc_edge
    import shc_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       msb_i,
    input  logic       lsb_i,
    input  logic       ser_i,
    output fill_t      fill_o
);
    mode_e mode;

    always_comb begin
        mode      = mode_e'(mode_i);
        fill_o.lo = left_fill(mode, msb_i, ser_i);
        fill_o.hi = right_fill(mode, msb_i, lsb_i, ser_i);
    end
endmodule

// File: rtl/shc_bit_cell.sv
module shc_bit_cell
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic load_i,
    input  logic from_lo_i,
    input  logic from_hi_i,
    output logic q_o
);
    logic nxt;

    always_comb begin
        nxt = q_o;
        if (ctl_i.clr)      nxt = 1'b0;
        else if (ctl_i.ld)  nxt = load_i;
        else if (ctl_i.shl) nxt = from_lo_i;
        else if (ctl_i.shr) nxt = from_hi_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= nxt;
    end
endmodule

// File: rtl/shc_carry.sv
module shc_carry
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic msb_i,
    input  logic lsb_i,
    output logic carry_o
);
    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) carry_o <= 1'b0;
        else if (ctl_i.shl)   carry_o <= msb_i;
        else if (ctl_i.shr)   carry_o <= lsb_i;
    end
endmodule

// File: rtl/shc_shifter.sv
module shc_shifter
    import shc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] par_o,
    output logic             ser_o,
    output logic             carry_o
);
    localparam int MSB = WIDTH - 1;

    ctl_t  ctl;
    fill_t fill;

    shc_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    shc_edge u_edge (
        .mode_i (mode_i),
        .msb_i  (par_o[MSB]),
        .lsb_i  (par_o[0]),
        .ser_i  (ser_i),
        .fill_o (fill)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lo_src;
        logic hi_src;

        if (i == 0) begin : g_lo_end
            assign lo_src = fill.lo;
        end else begin : g_lo_mid
            assign lo_src = par_o[i-1];
        end

        if (i == MSB) begin : g_hi_end
            assign hi_src = fill.hi;
        end else begin : g_hi_mid
            assign hi_src = par_o[i+1];
        end

        shc_bit_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .ctl_i     (ctl),
            .load_i    (par_i[i]),
            .from_lo_i (lo_src),
            .from_hi_i (hi_src),
            .q_o       (par_o[i])
        );
    end

    shc_carry u_carry (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .msb_i   (par_o[MSB]),
        .lsb_i   (par_o[0]),
        .carry_o (carry_o)
    );

    assign ser_o = par_o[0];

endmodule

// File: rtl/shc_shifter_chk.sv
module shc_shifter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op_i,
    input logic [1:0]       mode_i,
    input logic [WIDTH-1:0] par_i,
    input logic             ser_i,
    input logic [WIDTH-1:0] par_o,
    input logic             carry_o
);
    localparam int MSB = WIDTH - 1;

    p_reset_r1: assert property (@(posedge clk) rst |=> (par_o == '0) && !carry_o);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000 || op_i[2:1] == 2'b11 || op_i == 3'b101)
        |=> $stable(par_o) && $stable(carry_o));

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'b001 |=> (par_o == $past(par_i)) && $stable(carry_o));

    p_shl_r4: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'b010 |=> (par_o[MSB:1] == $past(par_o[MSB-1:0]))
                           && (carry_o == $past(par_o[MSB])));

    p_shr_r5: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'b011 |=> (par_o[MSB-1:0] == $past(par_o[MSB:1]))
                           && (carry_o == $past(par_o[0])));

    p_logic_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011 && mode_i == 2'b00) |=> !par_o[MSB]);

    p_arith_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011 && mode_i == 2'b01) |=> par_o[MSB] == $past(par_o[MSB]));

    p_rot_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b010 && mode_i == 2'b10) |=> par_o[0] == carry_o);

    p_serial_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011 && mode_i == 2'b11) |=> par_o[MSB] == $past(ser_i));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'b100 |=> (par_o == '0) && !carry_o);

endmodule

bind shc_shifter shc_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .mode_i  (mode_i),
    .par_i   (par_i),
    .ser_i   (ser_i),
    .par_o   (par_o),
    .carry_o (carry_o)
);

// File: tb/tb_shc_shifter.sv
`timescale 1ns/1ps
module tb_shc_shifter;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op_i = 3'b000;
    logic [1:0]   mode_i = 2'b00;
    logic [W-1:0] par_i = '0;
    logic         ser_i = 1'b0;
    logic [W-1:0] par_o;
    logic         ser_o;
    logic         carry_o;

    always #2 clk = ~clk;

    shc_shifter #(.WIDTH(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op_i),
        .mode_i  (mode_i),
        .par_i   (par_i),
        .ser_i   (ser_i),
        .par_o   (par_o),
        .ser_o   (ser_o),
        .carry_o (carry_o)
    );

    typedef struct {
        logic [W-1:0] q;
        logic         c;
        string        tag;
    } item_t;

    item_t        sbq[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    logic [W-1:0] mq = '0;
    logic         mc = 1'b0;
    bit           done = 0;

    // driver: apply one operation and queue the expected result
    task automatic step(input logic r, input logic [2:0] o, input logic [1:0] m,
                        input logic [W-1:0] dv, input logic s, input string tag);
        item_t it;
        logic  f;
        @(negedge clk);
        rst = r; op_i = o; mode_i = m; par_i = dv; ser_i = s;
        if (r) begin
            mq = '0; mc = 1'b0;
        end else begin
            case (o)
                3'b001: mq = dv;
                3'b010: begin
                    f  = (m == 2'b10) ? mq[W-1] : (m == 2'b11) ? s : 1'b0;
                    mc = mq[W-1];
                    mq = {mq[W-2:0], f};
                end
                3'b011: begin
                    f  = (m == 2'b01) ? mq[W-1] : (m == 2'b10) ? mq[0] :
                         (m == 2'b11) ? s : 1'b0;
                    mc = mq[0];
                    mq = {f, mq[W-1:1]};
                end
                3'b100: begin mq = '0; mc = 1'b0; end
                default: ;
            endcase
        end
        it.q = mq; it.c = mc; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compare one queued item per clock, 1 ns after the edge
    always @(posedge clk) begin
        item_t it;
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_cmp++;
            if (par_o !== it.q || carry_o !== it.c) begin
                n_bad++;
                $display("FAIL %s q=%b exp %b carry=%b exp %b",
                         it.tag, par_o, it.q, carry_o, it.c);
            end
            n_cmp++;
            if (ser_o !== it.q[0]) begin
                n_bad++;
                $display("FAIL R11 ser_o=%b exp %b (%s)", ser_o, it.q[0], it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(1, 3'b000, 2'b00, '0, 0, "R1 reset");
        step(0, 3'b001, 2'b00, 5'b10110, 0, "R3 load");
        step(0, 3'b000, 2'b00, 5'b11111, 1, "R2 hold");
        step(0, 3'b101, 2'b01, 5'b00001, 1, "R2 code 101");
        step(0, 3'b110, 2'b10, 5'b00001, 1, "R2 code 110");
        step(0, 3'b111, 2'b11, 5'b00001, 1, "R2 code 111");
        // logical
        step(0, 3'b010, 2'b00, '0, 1, "R4 R6 logical left");
        step(0, 3'b010, 2'b00, '0, 1, "R4 R6 logical left");
        step(0, 3'b011, 2'b00, '0, 1, "R5 R6 logical right");
        step(0, 3'b001, 2'b00, 5'b00000, 0, "R3 load keeps carry");
        // arithmetic
        step(0, 3'b001, 2'b00, 5'b10011, 0, "R3 load");
        step(0, 3'b011, 2'b01, '0, 0, "R5 R7 arith right");
        step(0, 3'b011, 2'b01, '0, 0, "R5 R7 arith right");
        step(0, 3'b011, 2'b01, '0, 0, "R5 R7 arith right");
        step(0, 3'b010, 2'b01, '0, 1, "R4 R7 arith left");
        step(0, 3'b001, 2'b00, 5'b01011, 0, "R3 load");
        step(0, 3'b011, 2'b01, '0, 1, "R7 arith right positive");
        // rotate
        step(0, 3'b001, 2'b00, 5'b10010, 0, "R3 load");
        for (int k = 0; k < 3; k++) step(0, 3'b010, 2'b10, '0, 0, "R8 rotate left");
        for (int k = 0; k < 3; k++) step(0, 3'b011, 2'b10, '0, 0, "R8 rotate right");
        step(0, 3'b011, 2'b10, '0, 0, "R8 rotate right");
        // serial load of 5 bits, then left serial entry
        step(0, 3'b100, 2'b00, '0, 0, "R10 clear");
        step(0, 3'b011, 2'b11, '0, 1, "R9 serial right");
        step(0, 3'b011, 2'b11, '0, 0, "R9 serial right");
        step(0, 3'b011, 2'b11, '0, 1, "R9 serial right");
        step(0, 3'b011, 2'b11, '0, 1, "R9 serial right");
        step(0, 3'b011, 2'b11, '0, 0, "R9 serial right");
        step(0, 3'b010, 2'b11, '0, 1, "R9 serial left");
        step(0, 3'b010, 2'b11, '0, 0, "R9 serial left");
        // boundary: all ones shifted out
        step(0, 3'b001, 2'b00, 5'b11111, 0, "R3 load ones");
        for (int k = 0; k < 5; k++) step(0, 3'b011, 2'b00, '0, 1, "R5 R6 drain right");
        step(0, 3'b011, 2'b00, '0, 1, "R5 empty shift");
        step(0, 3'b001, 2'b00, 5'b10001, 0, "R3 load");
        step(0, 3'b010, 2'b00, '0, 0, "R4 carry set");
        step(0, 3'b100, 2'b10, 5'b11111, 1, "R10 clear");
        step(0, 3'b001, 2'b00, 5'b01110, 0, "R3 load");
        step(1, 3'b001, 2'b00, 5'b11111, 1, "R1 reset over load");
        step(0, 3'b000, 2'b00, '0, 0, "R2 hold after reset");
        @(negedge clk);
        op_i = 3'b000;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule